// File: doc/BRIEF.md
# Prioritized Vector Interrupt Core

This core keeps the interrupt state of one processor for 256 vectors. Three bitmaps hold the requests waiting for service, the vectors currently being serviced and, per vector, whether the request came in level-triggered. A task priority value written by software, together with the highest vector in service, sets a processor priority. Only a pending vector whose priority class is above that level is offered to the CPU.

The CPU takes an offered vector with an acknowledge strobe. When it finishes the handler, it signals end of interrupt. That retires the highest vector in service. If that vector was level-triggered, the core also sends a one-cycle broadcast naming it, so the interrupt source can re-arm.

Task priority can be written as a full byte, or through a 4-bit control-register view that holds only the class.

Top module: `vec_irq_core`

## Requirements
- R1: After reset, the pending, in-service and trigger bitmaps, the task priority and the processor priority are all zero. No vector is offered and no broadcast is active.
- R2: An accept of vector v (16..255) while `coreEn` is high sets pending bit v. It sets v's trigger bit for level (`accLevel`=1) and clears it for edge. `accOk` is high in that cycle only when the pending bit was not already set.
- R3: The processor priority register is loaded one cycle after a task priority or in-service change. Let S be the highest in-service vector, or 0 when none is in service. When tpr[7:4] >= S[7:4] the priority equals tpr[7:0]; otherwise it is {S[7:4],4'h0}.
- R4: `intReq` is high when the core is enabled and a vector is pending whose value with the low nibble cleared is strictly greater than the processor priority. `intVector` is then the highest-numbered pending vector.
- R5: An acknowledge while `intReq` is high sets the offered vector's in-service bit and clears its pending bit.
- R6: End of interrupt clears only the highest in-service bit. If that vector's trigger bit was set, the trigger bit is cleared and `eoiBcast` pulses high one cycle later for a single cycle, with `eoiBcastVec` equal to the vector. Edge-triggered vectors give no broadcast.
- R7: End of interrupt with nothing in service changes no state and gives no broadcast.
- R8: With `coreEn` low, accepts are dropped and `intReq` stays low.
- R9: A level-triggered accept of a vector already pending is dropped and its trigger bit is kept. An edge-triggered accept of a pending vector reports `accOk`=0 and clears the trigger bit.
- R10: A task priority write stores 8 bits. A control-register write of value c sets the task priority to {c,4'h0}. `crRd` returns tpr[7:4]. If both writes occur in one cycle, the byte write wins.
- R11: Accepts of vectors 0..15 are ignored.
- R12: If acknowledge and end of interrupt arrive in the same cycle, end of interrupt is performed and the acknowledge is ignored.
- R13: An accept of the vector being acknowledged in the same cycle sees the pending bit as already cleared. The vector becomes pending again, with `accOk`=1.
- R14: `intReq` is held low for the one cycle after an acknowledge, an effective end of interrupt or any task priority write, while the processor priority is still being reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreEn | input | 1 | Core enable qualifier |
| accValid | input | 1 | Interrupt request strobe |
| accVector | input | 8 | Requested vector |
| accLevel | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| accOk | output | 1 | Request newly set a pending bit |
| intReq | output | 1 | A deliverable vector is offered |
| intVector | output | 8 | Offered vector |
| ackStrobe | input | 1 | CPU takes the offered vector |
| eoiStrobe | input | 1 | End of interrupt |
| tprWrEn | input | 1 | Task priority byte write |
| tprWrData | input | 8 | Task priority byte |
| tprRd | output | 8 | Task priority value |
| crWrEn | input | 1 | Control-register view write |
| crWrData | input | 4 | Priority class to write |
| crRd | output | 4 | Priority class read |
| pprOut | output | 8 | Processor priority |
| eoiBcast | output | 1 | End-of-interrupt broadcast pulse |
| eoiBcastVec | output | 8 | Vector of the broadcast |

## Verification
The two functions that can meet in one cycle are a new request and the acknowledge of that same vector. The bench provokes this by raising `accValid` with the offered vector while `ackStrobe` is high. It judges the outcome in three steps: `accOk` must read 1 in that cycle; once the priority settles, the vector must no longer be offered; and after the end of interrupt it must be offered again. A second collision, acknowledge together with end of interrupt, is judged by whether the pending vector is still offered afterwards.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VEC_W   = 8;
  localparam int CLS_W   = 4;
  localparam int RSV_VEC = 16;

  typedef struct packed {
    logic             accSet;
    logic             accLevel;
    logic [VEC_W-1:0] accVec;
    logic             ackSet;
    logic [VEC_W-1:0] ackVec;
    logic             eoiDo;
    logic             tprWr;
    logic [VEC_W-1:0] tprVal;
  } vicStrobe_t;
endpackage

// File: rtl/vic_prio_find.sv
module vic_prio_find #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8
) (
  input  logic [NUM_WORDS*WORD_W-1:0]         bits,
  output logic                                found,
  output logic [$clog2(NUM_WORDS*WORD_W)-1:0] idx
);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int WIDX_W = $clog2(NUM_WORDS);

  logic             wordAny [NUM_WORDS];
  logic [BIT_W-1:0] wordMsb [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [BIT_W-1:0] msb;
    always_comb begin
      msb = '0;
      for (int b = 0; b < WORD_W; b++)
        if (bits[w*WORD_W+b]) msb = b[BIT_W-1:0];
    end
    assign wordAny[w] = |bits[w*WORD_W +: WORD_W];
    assign wordMsb[w] = msb;
  end

  // later (higher) words overwrite earlier ones: highest word wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wordAny[w]) begin
        found = 1'b1;
        idx   = {w[WIDX_W-1:0], wordMsb[w]};
      end
    end
  end
endmodule

// File: rtl/vic_dp.sv
module vic_dp
  import vic_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  vicStrobe_t       st,
  input  logic [VEC_W-1:0] probeVec,
  output logic             pendHit,
  output logic             irrFound,
  output logic [VEC_W-1:0] irrVec,
  output logic             isrAny,
  output logic [VEC_W-1:0] ppr,
  output logic [VEC_W-1:0] tpr,
  output logic             eoiBcast,
  output logic [VEC_W-1:0] eoiBcastVec
);
  localparam int NV        = 1 << VEC_W;
  localparam int NUM_WORDS = NV / WORD_W;

  logic [NV-1:0]    irr, isr, tmr, tmrNext;
  logic [NV-1:0]    accMask, ackMask, eoiMask;
  logic [VEC_W-1:0] isrTop, isrv, pprNext;
  logic             eoiValid;

  vic_prio_find #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) i_irrFind (
    .bits(irr), .found(irrFound), .idx(irrVec));
  vic_prio_find #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) i_isrFind (
    .bits(isr), .found(isrAny), .idx(isrTop));

  assign pendHit  = irr[probeVec];
  assign eoiValid = st.eoiDo && isrAny;
  assign accMask  = st.accSet ? (NV'(1) << st.accVec) : '0;
  assign ackMask  = st.ackSet ? (NV'(1) << st.ackVec) : '0;
  assign eoiMask  = eoiValid  ? (NV'(1) << isrTop)    : '0;

  always_comb begin
    tmrNext = tmr & ~eoiMask;
    if (st.accSet) tmrNext[st.accVec] = st.accLevel;
  end

  assign isrv = isrAny ? isrTop : '0;
  always_comb begin
    if (tpr[VEC_W-1 -: CLS_W] >= isrv[VEC_W-1 -: CLS_W]) pprNext = tpr;
    else pprNext = {isrv[VEC_W-1 -: CLS_W], {(VEC_W-CLS_W){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr         <= '0;
      isr         <= '0;
      tmr         <= '0;
      tpr         <= '0;
      ppr         <= '0;
      eoiBcast    <= 1'b0;
      eoiBcastVec <= '0;
    end else begin
      irr         <= (irr & ~ackMask) | accMask;
      isr         <= (isr & ~eoiMask) | ackMask;
      tmr         <= tmrNext;
      ppr         <= pprNext;
      eoiBcast    <= eoiValid && tmr[isrTop];
      eoiBcastVec <= isrTop;
      if (st.tprWr) tpr <= st.tprVal;
    end
  end

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    st.ackSet |=> isr[$past(st.ackVec)]); // R5
  AST_PPR_LOW_FROM_TPR: assert property (@(posedge clk) disable iff (!rstN)
    (ppr[VEC_W-CLS_W-1:0] != '0) |-> (ppr == $past(tpr))); // R3
  AST_BCAST_FROM_EOI: assert property (@(posedge clk) disable iff (!rstN)
    eoiBcast |-> $past(st.eoiDo)); // R6
  AST_RESERVED_NEVER_PEND: assert property (@(posedge clk) disable iff (!rstN)
    irr[RSV_VEC-1:0] == '0); // R11
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             coreEn,
  input  logic             accValid,
  input  logic [VEC_W-1:0] accVector,
  input  logic             accLevel,
  input  logic             ackStrobe,
  input  logic             eoiStrobe,
  input  logic             tprWrEn,
  input  logic [VEC_W-1:0] tprWrData,
  input  logic             crWrEn,
  input  logic [CLS_W-1:0] crWrData,
  input  logic             pendHit,
  input  logic             irrFound,
  input  logic [VEC_W-1:0] irrVec,
  input  logic             isrAny,
  input  logic [VEC_W-1:0] ppr,
  output vicStrobe_t       st,
  output logic             intReq,
  output logic [VEC_W-1:0] intVector,
  output logic             accOk
);
  logic stale;
  logic ackDo, pendSeen, accDo, tprWr;

  assign intVector = irrVec;
  assign intReq    = coreEn && !stale && irrFound &&
                     ({irrVec[VEC_W-1 -: CLS_W], {(VEC_W-CLS_W){1'b0}}} > ppr);

  assign ackDo    = ackStrobe && !eoiStrobe && intReq;
  assign pendSeen = pendHit && !(ackDo && (intVector == accVector));
  assign accDo    = accValid && coreEn && (accVector >= VEC_W'(RSV_VEC)) &&
                    !(accLevel && pendSeen);
  assign accOk    = accDo && !pendSeen;
  assign tprWr    = tprWrEn || crWrEn;

  always_comb begin
    st          = '0;
    st.accSet   = accDo;
    st.accLevel = accLevel;
    st.accVec   = accVector;
    st.ackSet   = ackDo;
    st.ackVec   = intVector;
    st.eoiDo    = eoiStrobe;
    st.tprWr    = tprWr;
    st.tprVal   = tprWrEn ? tprWrData : {crWrData, {(VEC_W-CLS_W){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) stale <= 1'b0;
    else       stale <= ackDo || (eoiStrobe && isrAny) || tprWr;
  end

  AST_NO_OFFER_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    st.ackSet |=> !intReq); // R14
  AST_NO_OFFER_AFTER_TPR: assert property (@(posedge clk) disable iff (!rstN)
    st.tprWr |=> !intReq); // R14
endmodule

// File: rtl/vec_irq_core.sv
module vec_irq_core
  import vic_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             coreEn,
  input  logic             accValid,
  input  logic [VEC_W-1:0] accVector,
  input  logic             accLevel,
  output logic             accOk,
  output logic             intReq,
  output logic [VEC_W-1:0] intVector,
  input  logic             ackStrobe,
  input  logic             eoiStrobe,
  input  logic             tprWrEn,
  input  logic [VEC_W-1:0] tprWrData,
  output logic [VEC_W-1:0] tprRd,
  input  logic             crWrEn,
  input  logic [CLS_W-1:0] crWrData,
  output logic [CLS_W-1:0] crRd,
  output logic [VEC_W-1:0] pprOut,
  output logic             eoiBcast,
  output logic [VEC_W-1:0] eoiBcastVec
);
  vicStrobe_t       st;
  logic             pendHit, irrFound, isrAny;
  logic [VEC_W-1:0] irrVec, ppr, tpr;

  vic_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .coreEn(coreEn),
    .accValid(accValid), .accVector(accVector), .accLevel(accLevel),
    .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
    .tprWrEn(tprWrEn), .tprWrData(tprWrData),
    .crWrEn(crWrEn), .crWrData(crWrData),
    .pendHit(pendHit), .irrFound(irrFound), .irrVec(irrVec),
    .isrAny(isrAny), .ppr(ppr),
    .st(st), .intReq(intReq), .intVector(intVector), .accOk(accOk));

  vic_dp #(.WORD_W(WORD_W)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .probeVec(accVector),
    .pendHit(pendHit), .irrFound(irrFound), .irrVec(irrVec),
    .isrAny(isrAny), .ppr(ppr), .tpr(tpr),
    .eoiBcast(eoiBcast), .eoiBcastVec(eoiBcastVec));

  assign tprRd  = tpr;
  assign crRd   = tpr[VEC_W-1 -: CLS_W];
  assign pprOut = ppr;
endmodule

// File: tb/test_vec_irq_core.sv
`timescale 1ns/1ps
module test_vec_irq_core;
  logic       clk = 1'b0;
  logic       rstN, coreEn, accValid, accLevel, accOk, intReq;
  logic [7:0] accVector, intVector, tprWrData, tprRd, pprOut, eoiBcastVec;
  logic       ackStrobe, eoiStrobe, tprWrEn, crWrEn, eoiBcast;
  logic [3:0] crWrData, crRd;

  int nChk = 0;
  int nErr = 0;
  logic [7:0] expBc[$];

  always #2.5 clk = ~clk;

  vec_irq_core i_vec_irq_core (
    .clk(clk), .rstN(rstN), .coreEn(coreEn), .accValid(accValid),
    .accVector(accVector), .accLevel(accLevel), .accOk(accOk),
    .intReq(intReq), .intVector(intVector), .ackStrobe(ackStrobe),
    .eoiStrobe(eoiStrobe), .tprWrEn(tprWrEn), .tprWrData(tprWrData),
    .tprRd(tprRd), .crWrEn(crWrEn), .crWrData(crWrData), .crRd(crRd),
    .pprOut(pprOut), .eoiBcast(eoiBcast), .eoiBcastVec(eoiBcastVec));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic offer(input logic expReq, input logic [7:0] expVec, input string req);
    check(req, "intReq", intReq, expReq);
    if (expReq) check(req, "intVector", intVector, expVec);
  endtask

  task automatic accept(input logic [7:0] v, input logic lvl, input logic expOk,
                        input string req);
    accValid = 1'b1; accVector = v; accLevel = lvl;
    #1 check(req, "accOk", accOk, expOk);
    step();
    accValid = 1'b0;
  endtask

  task automatic ack(input logic [7:0] expVec, input string req);
    ackStrobe = 1'b1;
    #1 offer(1'b1, expVec, req);
    step();
    ackStrobe = 1'b0;
    check("R14", "intReq after ack", intReq, 1'b0);
    step();
  endtask

  task automatic eoi(input logic bc, input logic [7:0] v);
    if (bc) expBc.push_back(v);
    eoiStrobe = 1'b1;
    step();
    eoiStrobe = 1'b0;
    step();
  endtask

  // scoreboard monitor for end-of-interrupt broadcasts (R6)
  always @(negedge clk) begin
    if (rstN === 1'b1 && eoiBcast === 1'b1) begin
      nChk++;
      if (expBc.size() == 0) begin
        nErr++;
        $display("FAIL R6 unexpected broadcast: actual=%0h expected=none", eoiBcastVec);
      end else begin
        logic [7:0] e;
        e = expBc.pop_front();
        if (eoiBcastVec !== e) begin
          nErr++;
          $display("FAIL R6 broadcast vector: actual=%0h expected=%0h", eoiBcastVec, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nErr++; nChk++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    rstN = 1'b0; coreEn = 1'b1; accValid = 1'b0; accVector = '0; accLevel = 1'b0;
    ackStrobe = 1'b0; eoiStrobe = 1'b0; tprWrEn = 1'b0; tprWrData = '0;
    crWrEn = 1'b0; crWrData = '0;
    repeat (3) step();
    rstN = 1'b1;
    #1;
    check("R1", "intReq", intReq, 1'b0);
    check("R1", "ppr", pprOut, 8'h00);
    check("R1", "tpr", tprRd, 8'h00);
    check("R1", "cr", crRd, 4'h0);
    check("R1", "bcast", eoiBcast, 1'b0);

    accept(8'h05, 1'b0, 1'b0, "R11");
    offer(1'b0, 8'h00, "R11");

    accept(8'h31, 1'b0, 1'b1, "R2");
    accept(8'h75, 1'b1, 1'b1, "R2");
    offer(1'b1, 8'h75, "R4");
    accept(8'h75, 1'b1, 1'b0, "R9");

    ack(8'h75, "R5");
    check("R3", "ppr in service", pprOut, 8'h70);
    offer(1'b0, 8'h00, "R4");

    tprWrEn = 1'b1; tprWrData = 8'h4A; step(); tprWrEn = 1'b0;
    check("R10", "tpr byte", tprRd, 8'h4A);
    check("R10", "cr read", crRd, 4'h4);
    check("R14", "intReq after tpr", intReq, 1'b0);
    step();
    check("R3", "ppr isr class wins", pprOut, 8'h70);

    eoi(1'b1, 8'h75);
    check("R3", "ppr tpr wins", pprOut, 8'h4A);
    offer(1'b0, 8'h00, "R4");

    crWrEn = 1'b1; crWrData = 4'h2; step(); crWrEn = 1'b0;
    check("R10", "tpr from cr", tprRd, 8'h20);
    check("R10", "cr read", crRd, 4'h2);
    check("R14", "intReq after cr", intReq, 1'b0);
    step();
    check("R3", "ppr", pprOut, 8'h20);
    offer(1'b1, 8'h31, "R4");

    // R7: end of interrupt with nothing in service
    eoiStrobe = 1'b1; step(); eoiStrobe = 1'b0;
    offer(1'b1, 8'h31, "R7");
    check("R7", "ppr", pprOut, 8'h20);

    // R12: acknowledge and end of interrupt together
    ackStrobe = 1'b1; eoiStrobe = 1'b1; step();
    ackStrobe = 1'b0; eoiStrobe = 1'b0;
    offer(1'b1, 8'h31, "R12");
    step();
    offer(1'b1, 8'h31, "R12");
    check("R12", "ppr", pprOut, 8'h20);

    // R13: accept of the vector being acknowledged
    accValid = 1'b1; accVector = 8'h31; accLevel = 1'b0; ackStrobe = 1'b1;
    #1 check("R13", "accOk", accOk, 1'b1);
    step();
    accValid = 1'b0; ackStrobe = 1'b0;
    check("R14", "intReq", intReq, 1'b0);
    step();
    check("R13", "ppr", pprOut, 8'h30);
    offer(1'b0, 8'h00, "R13");
    eoi(1'b0, 8'h00);
    offer(1'b1, 8'h31, "R13");

    // R6: nested service, only highest retired
    accept(8'h88, 1'b1, 1'b1, "R2");
    ack(8'h88, "R5");
    check("R3", "ppr", pprOut, 8'h80);
    accept(8'h95, 1'b0, 1'b1, "R2");
    offer(1'b1, 8'h95, "R4");
    ack(8'h95, "R5");
    check("R3", "ppr nested", pprOut, 8'h90);
    eoi(1'b0, 8'h00);
    check("R6", "ppr after first eoi", pprOut, 8'h80);
    offer(1'b0, 8'h00, "R6");
    eoi(1'b1, 8'h88);
    check("R6", "ppr after second eoi", pprOut, 8'h20);
    offer(1'b1, 8'h31, "R6");

    // R9: edge re-accept clears the trigger bit, so no broadcast
    accept(8'hC4, 1'b1, 1'b1, "R9");
    accept(8'hC4, 1'b0, 1'b0, "R9");
    ack(8'hC4, "R9");
    eoi(1'b0, 8'h00);
    offer(1'b1, 8'h31, "R9");

    // R8: disabled core
    coreEn = 1'b0;
    #1 check("R8", "intReq disabled", intReq, 1'b0);
    accept(8'h50, 1'b1, 1'b0, "R8");
    check("R8", "intReq disabled", intReq, 1'b0);
    coreEn = 1'b1;
    #1 offer(1'b1, 8'h31, "R8");

    // R10: both writes in one cycle
    tprWrEn = 1'b1; tprWrData = 8'h3C; crWrEn = 1'b1; crWrData = 4'hF;
    step();
    tprWrEn = 1'b0; crWrEn = 1'b0;
    check("R10", "byte write wins", tprRd, 8'h3C);
    check("R10", "cr read", crRd, 4'h3);

    step();
    check("R6", "broadcasts outstanding", expBc.size(), 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule